// File: doc/BRIEF.md
# Floating Data Line Keeper

This block models what a reader sees on an 8-bit external CPU data bus whose lines can float. On every bus cycle it takes the data actually placed on the bus and a per-bit drive mask. Bits that are driven pass straight through to the resolved read data. Bits that nobody drives show the last value driven on that line. Each line keeps its own decay counter, and after a configurable number of bus cycles without being driven, the retained value on that line fades to 0.

A write cycle puts all bits on the bus, so every line is refreshed. A read cycle drives only the bits in its mask, which may be all of them, some of them or none. A 2-bit override input models the effect a cartridge can have on the floating lines:

- Normal decay.
- Indefinite hold.
- Undriven bits forced low.
- Undriven bits forced high.

The resolved data is formed in the same cycle as the access, so the block can sit directly in a bus-return mux.

Top module: `floatbus_keeper`

## Requirements
- R1: On a strobed read, each bit whose drive-mask bit is 1 appears on `rd_data` in the same cycle, equal to the `cyc_data` bit.
- R2: On a strobed write (`cyc_write`=1), all bits of `rd_data` equal `cyc_data` whatever the mask, and every line captures its `cyc_data` bit.
- R3: With override mode 2'b00 (decay), an undriven bit reads as the last value driven on that line while its counter has not run out.
- R4: Driving a bit restarts that bit's decay counter only; the counters of undriven bits keep counting.
- R5: In decay mode, a value driven on a line is still returned on exactly `DECAY_STROBES` later strobes that leave the line undriven. From the next such strobe on, the line reads 0.
- R6: With override mode 2'b01 (hold), counters do not advance and undriven bits keep returning their retained value. When the mode returns to 2'b00, counting resumes from the remaining count.
- R7: With override mode 2'b10, undriven bits read 0. Capture and counting continue as in decay mode.
- R8: With override mode 2'b11, undriven bits read 1. Capture and counting continue as in decay mode.
- R9: After reset, every retained bit is 0 and every counter has run out, so undriven bits read 0 in decay mode.
- R10: Clock cycles with `cyc_stb`=0 neither capture data nor advance any counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_stb | input | 1 | One bus cycle takes place in this clock |
| cyc_write | input | 1 | 1 = write cycle (drives all bits), 0 = read cycle |
| cyc_data | input | DATA_W | Data placed on the bus by the active driver |
| cyc_mask | input | DATA_W | Per-bit drive mask for read cycles (1 = driven) |
| ovr_mode | input | 2 | 00 decay, 01 hold, 10 undriven low, 11 undriven high |
| rd_data | output | DATA_W | Resolved value a reader sees this cycle |

## Verification
The assertions assume that `cyc_data`, `cyc_mask`, `cyc_write` and `ovr_mode` are settled before each rising edge and only change between edges. The stimulus meets this by changing all inputs on the falling edge. The retention property that follows a write also assumes `DECAY_STROBES` is at least 1, which the parameter range and the bench value of 4 satisfy. The bench keeps `ovr_mode` constant within each access and changes it only between strobes, so every mode-dependent property sees one mode per cycle.

// File: rtl/floatbus_pkg.sv
`timescale 1ns/1ps
package floatbus_pkg;

  typedef enum logic [1:0] {
    FB_DECAY  = 2'b00,
    FB_HOLD   = 2'b01,
    FB_FORCE0 = 2'b10,
    FB_FORCE1 = 2'b11
  } fb_mode_e;

endpackage

// File: rtl/floatbus_drive_decode.sv
`timescale 1ns/1ps
module floatbus_drive_decode #(
  parameter int DATA_W = 8
) (
  input  logic              is_write,
  input  logic [DATA_W-1:0] rd_mask,
  output logic [DATA_W-1:0] drive
);

  // A write cycle places every bit on the bus; a read only its masked bits.
  always_comb begin
    if (is_write) drive = '1;
    else          drive = rd_mask;
  end

endmodule

// File: rtl/floatbus_bit_cell.sv
`timescale 1ns/1ps
module floatbus_bit_cell #(
  parameter int unsigned DECAY_STROBES = 119_318,
  localparam int CNT_W = $clog2(DECAY_STROBES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  logic drive,
  input  logic din,
  input  logic freeze,
  output logic kept
);

  localparam logic [CNT_W-1:0] LOAD = CNT_W'(DECAY_STROBES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

  logic [CNT_W-1:0] life;

  always_ff @(posedge clk) begin
    if (rst) begin
      kept <= 1'b0;
      life <= '0;
    end else if (stb) begin
      if (drive) begin
        kept <= din;
        life <= LOAD;
      end else if (!freeze && life != '0) begin
        life <= life - LAST;
        if (life == LAST) kept <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/floatbus_fill_select.sv
`timescale 1ns/1ps
module floatbus_fill_select
  import floatbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [1:0]        mode,
  input  logic [DATA_W-1:0] kept,
  output logic [DATA_W-1:0] fill,
  output logic              freeze
);

  fb_mode_e m;
  assign m = fb_mode_e'(mode);

  always_comb begin
    fill   = kept;
    freeze = 1'b0;
    case (m)
      FB_DECAY:  fill = kept;
      FB_HOLD: begin
        fill   = kept;
        freeze = 1'b1;
      end
      FB_FORCE0: fill = '0;
      FB_FORCE1: fill = '1;
      default:   fill = kept;
    endcase
  end

endmodule

// File: rtl/floatbus_keeper.sv
`timescale 1ns/1ps
module floatbus_keeper #(
  parameter int          DATA_W        = 8,
  parameter int unsigned DECAY_STROBES = 119_318
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cyc_stb,
  input  logic              cyc_write,
  input  logic [DATA_W-1:0] cyc_data,
  input  logic [DATA_W-1:0] cyc_mask,
  input  logic [1:0]        ovr_mode,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] drive;
  logic [DATA_W-1:0] kept;
  logic [DATA_W-1:0] fill;
  logic              freeze;

  floatbus_drive_decode #(.DATA_W(DATA_W)) u_decode (
    .is_write (cyc_write),
    .rd_mask  (cyc_mask),
    .drive    (drive)
  );

  for (genvar b = 0; b < DATA_W; b++) begin : g_line
    floatbus_bit_cell #(.DECAY_STROBES(DECAY_STROBES)) u_cell (
      .clk    (clk),
      .rst    (rst),
      .stb    (cyc_stb),
      .drive  (drive[b]),
      .din    (cyc_data[b]),
      .freeze (freeze),
      .kept   (kept[b])
    );
  end

  floatbus_fill_select #(.DATA_W(DATA_W)) u_fill (
    .mode   (ovr_mode),
    .kept   (kept),
    .fill   (fill),
    .freeze (freeze)
  );

  assign rd_data = (cyc_data & drive) | (fill & ~drive);

endmodule

// File: rtl/floatbus_keeper_chk.sv
`timescale 1ns/1ps
module floatbus_keeper_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cyc_stb,
  input logic              cyc_write,
  input logic [DATA_W-1:0] cyc_data,
  input logic [DATA_W-1:0] cyc_mask,
  input logic [1:0]        ovr_mode,
  input logic [DATA_W-1:0] rd_data
);

  logic undriven_read;
  assign undriven_read = cyc_stb && !cyc_write && cyc_mask == '0;

  // R1
  masked_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_stb && !cyc_write) |-> (((rd_data ^ cyc_data) & cyc_mask) == '0));

  // R2
  write_all_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_stb && cyc_write) |-> (rd_data == cyc_data));

  // R3
  retain_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_stb && cyc_write) |=>
      (!(undriven_read && (ovr_mode == 2'b00 || ovr_mode == 2'b01))
       || rd_data == $past(cyc_data)));

  // R6
  hold_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (undriven_read && ovr_mode == 2'b01) |=>
      (!(undriven_read && ovr_mode == 2'b01) || rd_data == $past(rd_data)));

  // R7
  force_low_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_stb && !cyc_write && ovr_mode == 2'b10) |-> ((rd_data & ~cyc_mask) == '0));

  // R8
  force_high_chk: assert property (@(posedge clk) disable iff (rst)
    (cyc_stb && !cyc_write && ovr_mode == 2'b11) |-> ((rd_data | cyc_mask) == '1));

endmodule

bind floatbus_keeper floatbus_keeper_chk #(.DATA_W(DATA_W)) u_keeper_chk (
  .clk       (clk),
  .rst       (rst),
  .cyc_stb   (cyc_stb),
  .cyc_write (cyc_write),
  .cyc_data  (cyc_data),
  .cyc_mask  (cyc_mask),
  .ovr_mode  (ovr_mode),
  .rd_data   (rd_data)
);

// File: tb/test_floatbus_keeper.sv
`timescale 1ns/1ps
module test_floatbus_keeper;

  localparam int W = 8;
  localparam int unsigned LIFE = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cyc_stb = 1'b0;
  logic         cyc_write = 1'b0;
  logic [W-1:0] cyc_data = '0;
  logic [W-1:0] cyc_mask = '0;
  logic [1:0]   ovr_mode = 2'b00;
  logic [W-1:0] rd_data;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  floatbus_keeper #(.DATA_W(W), .DECAY_STROBES(LIFE)) i_floatbus_keeper (
    .clk(clk), .rst(rst), .cyc_stb(cyc_stb), .cyc_write(cyc_write),
    .cyc_data(cyc_data), .cyc_mask(cyc_mask), .ovr_mode(ovr_mode),
    .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  // One clock: inputs set at the falling edge, result sampled 1 ns later.
  task automatic cyc(input logic stb, input logic wr, input logic [W-1:0] d,
                     input logic [W-1:0] m, input logic [1:0] md, output logic [W-1:0] rd);
    @(negedge clk);
    cyc_stb = stb; cyc_write = wr; cyc_data = d; cyc_mask = m; ovr_mode = md;
    #1 rd = rd_data;
  endtask

  task automatic do_reset;
    logic [W-1:0] r;
    @(negedge clk); rst = 1'b1; cyc_stb = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    cyc(1'b1, 1'b0, 8'h00, 8'h00, 2'b00, r);
    chk("R9 reset undriven", r, 8'h00);
  endtask

  task automatic t_pass_write;
    logic [W-1:0] r;
    cyc(1'b1, 1'b0, 8'hA5, 8'hF0, 2'b00, r);
    chk("R1 masked pass", r, 8'hA0);
    cyc(1'b1, 1'b1, 8'h3C, 8'h00, 2'b00, r);
    chk("R2 write all bits", r, 8'h3C);
    cyc(1'b1, 1'b0, 8'hFF, 8'h00, 2'b00, r);
    chk("R3 retained after write", r, 8'h3C);
    cyc(1'b1, 1'b0, 8'hFF, 8'h0F, 2'b00, r);
    chk("R1 partial mask", r, 8'h3F);
    cyc(1'b1, 1'b0, 8'h00, 8'h00, 2'b00, r);
    chk("R3 retained after partial", r, 8'h3F);
  endtask

  task automatic t_decay;
    logic [W-1:0] r;
    do_reset();
    cyc(1'b1, 1'b1, 8'hFF, 8'h00, 2'b00, r);
    for (int i = 0; i < int'(LIFE); i++) begin
      cyc(1'b1, 1'b0, 8'h00, 8'h00, 2'b00, r);
      chk("R5 alive within window", r, 8'hFF);
    end
    cyc(1'b1, 1'b0, 8'h00, 8'h00, 2'b00, r);
    chk("R5 decayed to zero", r, 8'h00);
  endtask

  task automatic t_perbit;
    logic [W-1:0] r;
    do_reset();
    cyc(1'b1, 1'b1, 8'hFF, 8'h00, 2'b00, r);
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 8'h00, 8'h00, 2'b00, r);
    cyc(1'b1, 1'b0, 8'hFF, 8'h0F, 2'b00, r);
    chk("R4 refresh strobe", r, 8'hFF);
    cyc(1'b1, 1'b0, 8'h00, 8'h00, 2'b00, r);
    chk("R4 only refreshed bits kept", r, 8'h0F);
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 8'h00, 8'h00, 2'b00, r);
    chk("R4 refreshed bits last strobe", r, 8'h0F);
    cyc(1'b1, 1'b0, 8'h00, 8'h00, 2'b00, r);
    chk("R5 refreshed bits decayed", r, 8'h00);
  endtask

  task automatic t_hold;
    logic [W-1:0] r;
    do_reset();
    cyc(1'b1, 1'b1, 8'h81, 8'h00, 2'b00, r);
    cyc(1'b1, 1'b0, 8'h00, 8'h00, 2'b00, r);
    cyc(1'b1, 1'b0, 8'h00, 8'h00, 2'b00, r);
    for (int i = 0; i < 10; i++) cyc(1'b1, 1'b0, 8'h00, 8'h00, 2'b01, r);
    chk("R6 held past window", r, 8'h81);
    cyc(1'b1, 1'b0, 8'h00, 8'h00, 2'b00, r);
    chk("R6 resume count 1", r, 8'h81);
    cyc(1'b1, 1'b0, 8'h00, 8'h00, 2'b00, r);
    chk("R6 resume count 2", r, 8'h81);
    cyc(1'b1, 1'b0, 8'h00, 8'h00, 2'b00, r);
    chk("R6 resumed decay", r, 8'h00);
  endtask

  task automatic t_force;
    logic [W-1:0] r;
    do_reset();
    cyc(1'b1, 1'b1, 8'h5A, 8'h00, 2'b00, r);
    cyc(1'b1, 1'b0, 8'hFF, 8'h00, 2'b10, r);
    chk("R7 force low", r, 8'h00);
    cyc(1'b1, 1'b0, 8'h00, 8'h0F, 2'b11, r);
    chk("R8 force high", r, 8'hF0);
    cyc(1'b1, 1'b0, 8'h00, 8'h00, 2'b00, r);
    chk("R7 capture under force", r, 8'h50);
    cyc(1'b1, 1'b0, 8'h00, 8'h00, 2'b00, r);
    chk("R8 count under force", r, 8'h50);
    cyc(1'b1, 1'b0, 8'h00, 8'h00, 2'b00, r);
    chk("R7 counted during force", r, 8'h00);
  endtask

  task automatic t_nostrobe;
    logic [W-1:0] r;
    do_reset();
    cyc(1'b1, 1'b1, 8'h77, 8'h00, 2'b00, r);
    for (int i = 0; i < 10; i++) cyc(1'b0, (i % 2) == 0, 8'(i * 37), 8'hFF, 2'b00, r);
    for (int i = 0; i < int'(LIFE); i++) begin
      cyc(1'b1, 1'b0, 8'h00, 8'h00, 2'b00, r);
      chk("R10 idle cycles ignored", r, 8'h77);
    end
    cyc(1'b1, 1'b0, 8'h00, 8'h00, 2'b00, r);
    chk("R10 count unchanged by idle", r, 8'h00);
  endtask

  initial begin
    do_reset();
    t_pass_write();
    t_decay();
    t_perbit();
    t_hold();
    t_force();
    t_nostrobe();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule